// File: doc/BRIEF.md
# Speech Endpoint Detector

This block watches a stream of per-frame speech features and marks where an utterance begins and ends. Each frame arrives as one strobe carrying a short-term energy and a short-term zero-crossing count. A frame counts as speech when either feature is strictly above its own programmable threshold. A start is accepted only after a programmable number of consecutive speech frames. An end is accepted only after a programmable number of consecutive non-speech frames. The block reports both positions as 9-bit frame indices.

The controller is a five-state machine. Its states are SILENCE, CAND_START, SPEECH, CAND_END and DONE.
- SILENCE goes to CAND_START on a speech frame. It goes straight to SPEECH when the begin length is one.
- CAND_START goes to SPEECH when the run completes. It falls back to SILENCE on a non-speech frame.
- SPEECH goes to CAND_END on a non-speech frame. It goes straight to DONE when the end length is one.
- CAND_END goes to DONE when the silent run completes. It returns to SPEECH on a speech frame.
- Any state except DONE goes to DONE on overflow of the frame index or on a stream-end indication.

DONE holds its results until a clear or a reset. The thresholds and both run lengths are written through a small select/data write port. A clear input restarts detection and keeps that configuration.

Top module: `speech_span_finder`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, `start_found`, `end_found`, `err` and `result_vld` are 0, both indices are 0, the frame counter is 0 and the state is SILENCE. `clr` leaves the configuration unchanged.
- R2: When `cfg_we` is high, `cfg_sel` chooses the register that `cfg_data` is written to. The codes are: 0 for the energy threshold (bits 23:0), 1 for the zero-crossing threshold (bits 6:0), 2 for the begin run length (bits 7:0) and 3 for the end run length (bits 7:0). A frame in the same cycle as a write uses the old value.
- R3: A frame is speech when `frame_energy` is greater than the energy threshold, or when `frame_zc` is greater than the zero-crossing threshold. A value equal to its threshold does not qualify.
- R4: Once the begin-length number of consecutive speech frames has been seen, `start_found` is 1 in the cycle after the completing frame. `start_idx` is the index of the first frame of that run. A begin length of 0 acts as 1.
- R5: A non-speech frame before the start run completes discards the run. The next speech frame begins a new run with its own index.
- R6: Once the end-length number of consecutive non-speech frames has been seen after a start, `end_found` is 1 in the cycle after the completing frame. `end_idx` is the index of the last speech frame before that run. An end length of 0 acts as 1.
- R7: A speech frame during an end candidate run discards that run. Detection then continues in SPEECH.
- R8: The frame index counts accepted frames from 0. Cycles without `frame_vld`, and frames that arrive in DONE, change nothing.
- R9: If the frame with index 511 is accepted and does not confirm an end, `err` becomes 1 and the block goes to DONE. If that same frame confirms the end, there is no error.
- R10: `stream_end` outside DONE ends detection. With no start confirmed, `err` becomes 1. With a start confirmed, the end is confirmed at the last speech frame. A frame in the same cycle is processed first, and the overflow rule of R9 takes precedence.
- R11: `result_vld` is a one-cycle pulse in the cycle after the block enters DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous restart of detection |
| frame_vld | input | 1 | One frame's features are present |
| frame_energy | input | 24 | Short-term energy of the frame |
| frame_zc | input | 7 | Short-term zero-crossing count of the frame |
| stream_end | input | 1 | No further frames will arrive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_data | input | 24 | Configuration write data |
| start_idx | output | 9 | Index of the first frame of the utterance |
| end_idx | output | 9 | Index of the last frame of the utterance |
| start_found | output | 1 | Start has been confirmed |
| end_found | output | 1 | End has been confirmed |
| err | output | 1 | Index overflow, or stream ended without a start |
| result_vld | output | 1 | One-cycle pulse on completion |

## Verification
Two functions can meet in a single frame: the end run completing, and the frame index reaching 511. A third meeting point is a frame arriving together with `stream_end`. The bench provokes the first by feeding speech up to index 508 and then three silent frames with an end length of 3, so the silent run completes exactly on frame 511. It expects `end_found` with no error. The bench also feeds an unbroken speech stream, where frame 511 must raise `err` instead. For the second case, a speech frame is sent together with `stream_end`, and `end_idx` must equal that frame's own index.

// File: rtl/sed_pkg.sv
package sed_pkg;

    typedef enum logic [2:0] {
        ST_SILENCE    = 3'd0,
        ST_CAND_START = 3'd1,
        ST_SPEECH     = 3'd2,
        ST_CAND_END   = 3'd3,
        ST_DONE       = 3'd4
    } sed_state_t;

    localparam logic [1:0] CFG_E_TH  = 2'd0;
    localparam logic [1:0] CFG_Z_TH  = 2'd1;
    localparam logic [1:0] CFG_BEGIN = 2'd2;
    localparam logic [1:0] CFG_END   = 2'd3;

endpackage

// File: rtl/sed_cfg_regs.sv
module sed_cfg_regs
    import sed_pkg::*;
#(
    parameter int E_W       = 24,
    parameter int Z_W       = 7,
    parameter int RUN_W     = 8,
    parameter int E_TH_RST  = 1000,
    parameter int Z_TH_RST  = 20,
    parameter int BEGIN_RST = 4,
    parameter int END_RST   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [E_W-1:0]   wdata,
    output logic [E_W-1:0]   e_th,
    output logic [Z_W-1:0]   z_th,
    output logic [RUN_W-1:0] begin_len,
    output logic [RUN_W-1:0] end_len
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_th      <= E_W'(E_TH_RST);
            z_th      <= Z_W'(Z_TH_RST);
            begin_len <= RUN_W'(BEGIN_RST);
            end_len   <= RUN_W'(END_RST);
        end else if (we) begin
            unique case (sel)
                CFG_E_TH:  e_th      <= wdata;
                CFG_Z_TH:  z_th      <= wdata[Z_W-1:0];
                CFG_BEGIN: begin_len <= wdata[RUN_W-1:0];
                CFG_END:   end_len   <= wdata[RUN_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sed_frame_qualifier.sv
module sed_frame_qualifier #(
    parameter int E_W = 24,
    parameter int Z_W = 7
) (
    input  logic [E_W-1:0] energy,
    input  logic [Z_W-1:0] zc,
    input  logic [E_W-1:0] e_th,
    input  logic [Z_W-1:0] z_th,
    output logic           is_speech
);

    logic loud;
    logic busy;

    // strict comparisons: a feature equal to its threshold is not speech
    assign loud      = energy > e_th;
    assign busy      = zc > z_th;
    assign is_speech = loud | busy;

endmodule

// File: rtl/sed_run_counter.sv
module sed_run_counter #(
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first,
    input  logic             bump,
    input  logic [RUN_W-1:0] len,
    output logic             hit_first,
    output logic             hit_bump
);

    localparam logic [RUN_W-1:0] CNT_MAX = '1;
    localparam logic [RUN_W:0]   ONE_X   = (RUN_W+1)'(1);

    logic [RUN_W-1:0] cnt_q;
    logic [RUN_W:0]   len_eff;
    logic [RUN_W:0]   bumped;

    // a programmed length of zero behaves as a length of one
    assign len_eff   = (len == '0) ? ONE_X : {1'b0, len};
    assign bumped    = {1'b0, cnt_q} + ONE_X;
    assign hit_first = (len_eff <= ONE_X);
    assign hit_bump  = (bumped >= len_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (first) begin
            cnt_q <= RUN_W'(1);
        end else if (bump && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + RUN_W'(1);
        end
    end

endmodule

// File: rtl/speech_span_finder.sv
module speech_span_finder
    import sed_pkg::*;
#(
    parameter int E_W       = 24,
    parameter int Z_W       = 7,
    parameter int IDX_W     = 9,
    parameter int RUN_W     = 8,
    parameter int E_TH_RST  = 1000,
    parameter int Z_TH_RST  = 20,
    parameter int BEGIN_RST = 4,
    parameter int END_RST   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             frame_vld,
    input  logic [E_W-1:0]   frame_energy,
    input  logic [Z_W-1:0]   frame_zc,
    input  logic             stream_end,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [E_W-1:0]   cfg_data,
    output logic [IDX_W-1:0] start_idx,
    output logic [IDX_W-1:0] end_idx,
    output logic             start_found,
    output logic             end_found,
    output logic             err,
    output logic             result_vld
);

    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    logic [E_W-1:0]   e_th;
    logic [Z_W-1:0]   z_th;
    logic [RUN_W-1:0] begin_len;
    logic [RUN_W-1:0] end_len;
    logic             is_speech;

    sed_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] cand_q, cand_d;
    logic [IDX_W-1:0] last_q, last_d;
    logic [IDX_W-1:0] sidx_q, sidx_d;
    logic [IDX_W-1:0] eidx_q, eidx_d;
    logic             sf_q, sf_d;
    logic             ef_q, ef_d;
    logic             err_q, err_d;
    logic             rv_q, rv_d;

    logic             take;
    logic             s_first, s_bump, s_hit_first, s_hit_bump;
    logic             e_first, e_bump, e_hit_first, e_hit_bump;

    sed_cfg_regs #(
        .E_W(E_W), .Z_W(Z_W), .RUN_W(RUN_W),
        .E_TH_RST(E_TH_RST), .Z_TH_RST(Z_TH_RST),
        .BEGIN_RST(BEGIN_RST), .END_RST(END_RST)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .sel       (cfg_sel),
        .wdata     (cfg_data),
        .e_th      (e_th),
        .z_th      (z_th),
        .begin_len (begin_len),
        .end_len   (end_len)
    );

    sed_frame_qualifier #(.E_W(E_W), .Z_W(Z_W)) u_qual (
        .energy    (frame_energy),
        .zc        (frame_zc),
        .e_th      (e_th),
        .z_th      (z_th),
        .is_speech (is_speech)
    );

    sed_run_counter #(.RUN_W(RUN_W)) u_start_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .first     (s_first),
        .bump      (s_bump),
        .len       (begin_len),
        .hit_first (s_hit_first),
        .hit_bump  (s_hit_bump)
    );

    sed_run_counter #(.RUN_W(RUN_W)) u_end_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .first     (e_first),
        .bump      (e_bump),
        .len       (end_len),
        .hit_first (e_hit_first),
        .hit_bump  (e_hit_bump)
    );

    assign take = frame_vld && (state_q != ST_DONE);

    // next-state and result logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cand_d  = cand_q;
        last_d  = last_q;
        sidx_d  = sidx_q;
        eidx_d  = eidx_q;
        sf_d    = sf_q;
        ef_d    = ef_q;
        err_d   = err_q;
        rv_d    = 1'b0;
        s_first = 1'b0;
        s_bump  = 1'b0;
        e_first = 1'b0;
        e_bump  = 1'b0;

        if (take) begin
            if (idx_q != LAST_IDX) begin
                idx_d = idx_q + IDX_W'(1);
            end
            if (is_speech) begin
                last_d = idx_q;
            end

            unique case (state_q)
                ST_SILENCE: begin
                    if (is_speech) begin
                        cand_d  = idx_q;
                        s_first = 1'b1;
                        if (s_hit_first) begin
                            state_d = ST_SPEECH;
                            sf_d    = 1'b1;
                            sidx_d  = idx_q;
                        end else begin
                            state_d = ST_CAND_START;
                        end
                    end
                end
                ST_CAND_START: begin
                    if (is_speech) begin
                        s_bump = 1'b1;
                        if (s_hit_bump) begin
                            state_d = ST_SPEECH;
                            sf_d    = 1'b1;
                            sidx_d  = cand_q;
                        end
                    end else begin
                        state_d = ST_SILENCE;
                    end
                end
                ST_SPEECH: begin
                    if (!is_speech) begin
                        e_first = 1'b1;
                        if (e_hit_first) begin
                            state_d = ST_DONE;
                            ef_d    = 1'b1;
                            eidx_d  = last_q;
                            rv_d    = 1'b1;
                        end else begin
                            state_d = ST_CAND_END;
                        end
                    end
                end
                ST_CAND_END: begin
                    if (is_speech) begin
                        state_d = ST_SPEECH;
                    end else begin
                        e_bump = 1'b1;
                        if (e_hit_bump) begin
                            state_d = ST_DONE;
                            ef_d    = 1'b1;
                            eidx_d  = last_q;
                            rv_d    = 1'b1;
                        end
                    end
                end
                default: ;
            endcase

            // index exhausted without a confirmed end
            if (state_d != ST_DONE && idx_q == LAST_IDX) begin
                state_d = ST_DONE;
                err_d   = 1'b1;
                rv_d    = 1'b1;
            end
        end

        if (stream_end && state_d != ST_DONE) begin
            if (state_d == ST_SPEECH || state_d == ST_CAND_END) begin
                ef_d   = 1'b1;
                eidx_d = last_d;
            end else begin
                err_d  = 1'b1;
            end
            state_d = ST_DONE;
            rv_d    = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SILENCE;
            idx_q   <= '0;
            cand_q  <= '0;
            last_q  <= '0;
            sidx_q  <= '0;
            eidx_q  <= '0;
            sf_q    <= 1'b0;
            ef_q    <= 1'b0;
            err_q   <= 1'b0;
            rv_q    <= 1'b0;
        end else if (clr) begin
            state_q <= ST_SILENCE;
            idx_q   <= '0;
            cand_q  <= '0;
            last_q  <= '0;
            sidx_q  <= '0;
            eidx_q  <= '0;
            sf_q    <= 1'b0;
            ef_q    <= 1'b0;
            err_q   <= 1'b0;
            rv_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cand_q  <= cand_d;
            last_q  <= last_d;
            sidx_q  <= sidx_d;
            eidx_q  <= eidx_d;
            sf_q    <= sf_d;
            ef_q    <= ef_d;
            err_q   <= err_d;
            rv_q    <= rv_d;
        end
    end

    // outputs
    always_comb begin
        start_idx   = sidx_q;
        end_idx     = eidx_q;
        start_found = sf_q;
        end_found   = ef_q;
        err         = err_q;
        result_vld  = rv_q;
    end

endmodule

// File: rtl/sed_checker.sv
module sed_checker #(
    parameter int IDX_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             frame_vld,
    input logic             stream_end,
    input logic             start_found,
    input logic             end_found,
    input logic             err,
    input logic             result_vld,
    input logic [IDX_W-1:0] start_idx,
    input logic [IDX_W-1:0] end_idx
);

    AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!start_found && !end_found && !err && !result_vld)); // R1

    AST_START_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_found && !clr) |=> start_found); // R4

    AST_END_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        end_found |-> start_found); // R6

    AST_END_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (end_found && !err) |-> (end_idx >= start_idx)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_vld && !stream_end && !clr) |=>
        ($stable(start_found) && $stable(end_found) && $stable(err)
         && $stable(start_idx) && $stable(end_idx))); // R8

    AST_ERR_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> result_vld); // R9

    AST_RV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |=> !result_vld); // R11

endmodule

bind speech_span_finder sed_checker #(.IDX_W(IDX_W)) u_sed_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .frame_vld   (frame_vld),
    .stream_end  (stream_end),
    .start_found (start_found),
    .end_found   (end_found),
    .err         (err),
    .result_vld  (result_vld),
    .start_idx   (start_idx),
    .end_idx     (end_idx)
);

// File: tb/tb_speech_span_finder.sv
module tb_speech_span_finder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        frame_vld = 1'b0;
    logic [23:0] frame_energy = '0;
    logic [6:0]  frame_zc = '0;
    logic        stream_end = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [23:0] cfg_data = '0;
    logic [8:0]  start_idx, end_idx;
    logic        start_found, end_found, err, result_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state (0 silence,1 cand start,2 speech,3 cand end,4 done)
    int m_st, m_idx, m_run, m_cand, m_last, m_sidx, m_eidx;
    bit m_sf, m_ef, m_err, m_rv;
    int th_e = 1000, th_z = 20, bl = 4, el = 4;

    always #5 clk = ~clk;

    speech_span_finder dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .frame_vld(frame_vld),
        .frame_energy(frame_energy), .frame_zc(frame_zc), .stream_end(stream_end),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .start_idx(start_idx), .end_idx(end_idx), .start_found(start_found),
        .end_found(end_found), .err(err), .result_vld(result_vld)
    );

    function automatic void model_clear();
        m_st = 0; m_idx = 0; m_run = 0; m_cand = 0; m_last = 0;
        m_sidx = 0; m_eidx = 0; m_sf = 0; m_ef = 0; m_err = 0; m_rv = 0;
    endfunction

    function automatic bit is_sp(int e, int z);
        return (e > th_e) || (z > th_z);
    endfunction

    function automatic void model_step(bit v, int e, int z, bit se, bit c,
                                       bit we, int sel, int d);
        int blen, elen, cur;
        bit sp;
        blen = (bl == 0) ? 1 : bl;
        elen = (el == 0) ? 1 : el;
        m_rv = 0;
        if (c) begin
            model_clear();
        end else begin
            if (v && m_st != 4) begin
                sp  = is_sp(e, z);
                cur = m_idx;
                case (m_st)
                    0: if (sp) begin
                        m_cand = cur; m_run = 1;
                        if (m_run >= blen) begin m_st = 2; m_sf = 1; m_sidx = cur; end
                        else m_st = 1;
                    end
                    1: if (sp) begin
                        m_run++;
                        if (m_run >= blen) begin m_st = 2; m_sf = 1; m_sidx = m_cand; end
                    end else m_st = 0;
                    2: if (!sp) begin
                        m_run = 1;
                        if (m_run >= elen) begin m_st = 4; m_ef = 1; m_eidx = m_last; m_rv = 1; end
                        else m_st = 3;
                    end
                    3: if (sp) m_st = 2;
                    else begin
                        m_run++;
                        if (m_run >= elen) begin m_st = 4; m_ef = 1; m_eidx = m_last; m_rv = 1; end
                    end
                    default: ;
                endcase
                if (sp) m_last = cur;
                if (m_st != 4 && cur == 511) begin m_st = 4; m_err = 1; m_rv = 1; end
                if (cur != 511) m_idx++;
            end
            if (se && m_st != 4) begin
                if (m_st <= 1) m_err = 1;
                else begin m_ef = 1; m_eidx = m_last; end
                m_st = 4; m_rv = 1;
            end
        end
        if (we) begin
            case (sel)
                0: th_e = d & 24'hFFFFFF;
                1: th_z = d & 8'h7F;
                2: bl   = d & 8'hFF;
                default: el = d & 8'hFF;
            endcase
        end
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "start_found", int'(start_found), int'(m_sf));
        check(tag, "start_idx",   int'(start_idx),   m_sidx);
        check(tag, "end_found",   int'(end_found),   int'(m_ef));
        check(tag, "end_idx",     int'(end_idx),     m_eidx);
        check(tag, "err",         int'(err),         int'(m_err));
        check(tag, "result_vld",  int'(result_vld),  int'(m_rv));
    endtask

    task automatic cycle(string tag, bit v, int e, int z, bit se, bit c,
                         bit we, int sel, int d);
        @(negedge clk);
        frame_vld = v; frame_energy = 24'(e); frame_zc = 7'(z);
        stream_end = se; clr = c; cfg_we = we; cfg_sel = 2'(sel); cfg_data = 24'(d);
        model_step(v, e, z, se, c, we, sel, d);
        @(posedge clk);
        #1;
        compare_all(tag);
    endtask

    task automatic frame(string tag, int e, int z);
        cycle(tag, 1, e, z, 0, 0, 0, 0, 0);
    endtask

    task automatic idle(string tag);
        cycle(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic cfg(int sel, int d);
        cycle("R2", 0, 0, 0, 0, 0, 1, sel, d);
    endtask

    task automatic restart(int e, int z, int b, int n);
        cycle("R1", 0, 0, 0, 0, 1, 0, 0, 0);
        cfg(0, e); cfg(1, z); cfg(2, b); cfg(3, n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        process p;
        p = process::self();
        p.srandom(32'd1234);
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        compare_all("R1");

        // R3: equal to threshold is not speech, one above is
        restart(50, 10, 1, 2);
        frame("R3", 50, 10);
        frame("R3", 50, 10);
        frame("R3", 51, 0);
        frame("R3", 0, 11);

        // R4/R5: broken start run, then a full run; start index is run's first frame
        restart(50, 10, 3, 2);
        frame("R5", 90, 0); frame("R5", 90, 0); frame("R5", 0, 0);
        frame("R4", 90, 0); idle("R8"); frame("R4", 0, 20); frame("R4", 90, 0);
        // R7: broken end run, then end confirmed
        frame("R7", 0, 0); frame("R7", 90, 0);
        frame("R6", 0, 0); frame("R6", 0, 0);
        frame("R8", 90, 0); idle("R8");  // ignored in DONE

        // R2: write in same cycle as a frame uses old threshold
        restart(50, 10, 1, 1);
        cycle("R2", 1, 60, 0, 0, 0, 1, 0, 100);
        frame("R2", 0, 0);
        // R1: clear keeps configuration (threshold 100 now)
        cycle("R1", 0, 0, 0, 0, 1, 0, 0, 0);
        frame("R1", 80, 0); frame("R1", 101, 0);
        // R4: begin length 0 acts as 1
        restart(50, 10, 0, 0);
        frame("R4", 0, 0); frame("R4", 70, 0); frame("R6", 0, 0);

        // R10: stream end without start, then with a speech frame in the same cycle
        restart(50, 10, 2, 3);
        frame("R10", 90, 0);
        cycle("R10", 0, 0, 0, 1, 0, 0, 0, 0);
        restart(50, 10, 2, 3);
        frame("R10", 90, 0); frame("R10", 90, 0); frame("R10", 0, 0);
        cycle("R10", 1, 90, 0, 1, 0, 0, 0, 0);
        cycle("R10", 0, 0, 0, 1, 0, 0, 0, 0);

        // R9: unbroken speech overflows at index 511
        restart(50, 10, 1, 3);
        for (int i = 0; i < 512; i++) frame("R9", 90, 0);
        frame("R9", 0, 0);
        // R9: end run completes exactly on frame 511, no error
        restart(50, 10, 1, 3);
        for (int i = 0; i < 509; i++) frame("R9", 90, 0);
        for (int i = 0; i < 3; i++) frame("R9", 0, 0);
        idle("R11");

        // constrained random episodes
        for (int ep = 0; ep < 40; ep++) begin
            restart($urandom_range(80, 20), $urandom_range(20, 5),
                    $urandom_range(4, 0), $urandom_range(4, 0));
            for (int k = 0; k < 60; k++) begin
                int r;
                r = $urandom_range(9, 0);
                if (r == 0) idle("R8");
                else if (r < 6) frame("R3", $urandom_range(120, 40), $urandom_range(25, 0));
                else frame("R6", $urandom_range(60, 0), $urandom_range(12, 0));
            end
            if (ep % 3 == 0) cycle("R10", $urandom_range(1, 0), 90, 0, 1, 0, 0, 0, 0);
            idle("R11");
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule